// File: doc/BRIEF.md
# Byte-Wide Page-Programmed EEPROM Emulator

This block stands in for a parallel byte-wide EEPROM so that a host memory controller can be tested against it in simulation or on an FPGA. The host drives active-low chip enable, output enable and write enable, a 15-bit address and an 8-bit data bus. All of these are sampled and synchronised to a fast internal clock. The bidirectional data bus is split into an input, an output and a drive enable. The pad ring combines these into a tri-state pin.

Written bytes collect in a 64-byte page latch. When the host stops sending bytes for a configurable number of clock cycles, the load phase closes. The loaded bytes are then copied into a small backing store and a programming busy period starts. Its length is a parameter, so a simulation can use a short value in place of the multi-millisecond real one. During that period, reads return a polling byte instead of array contents, and new writes are ignored. An error flag reports a burst whose bytes do not all fall in the same page.

Top module: `eeprom_emul`

## Requirements
- R1: A byte is accepted when chip enable and write enable are both low while output enable is high. The address and data are taken from the last sampled cycle of that strobe, when the strobe ends.
- R2: A strobe with write enable low while output enable is also low stores nothing and starts no programming.
- R3: Address bits [5:0] select the page-latch slot. The backing store location is address bits [STORE_BITS-1:0], with the page taken from the first byte of the burst.
- R4: Every accepted byte restarts the load timer. Programming starts LOAD_TIMEOUT cycles after the last accepted byte, and `busy` rises two synchroniser cycles plus LOAD_TIMEOUT cycles after the strobe is released.
- R5: `busy` stays high for exactly PROG_CYCLES cycles and then falls.
- R6: A read while `busy` is high returns the last accepted byte with bit 7 inverted and bits [6:0] unchanged.
- R7: After programming, reads return the stored bytes. Page slots not loaded in the burst keep their previous contents.
- R8: Write strobes that end while `busy` is high are ignored and change no stored byte.
- R9: `err_flag` goes high when a byte in a burst has address bits [14:6] different from the first byte of that burst. That byte is still placed in its slot of the first byte's page. The flag stays high until the next burst begins.
- R10: `data_oe` is high only when chip enable and output enable are low and write enable is high. Read data appears three clocks after the inputs. `data_out` is zero whenever `data_oe` is low.
- R11: After reset, `busy`, `err_flag` and `data_oe` are low and every stored byte reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 15 | Byte address |
| data_in | input | 8 | Data bus, host to device |
| data_out | output | 8 | Data bus, device to host |
| data_oe | output | 1 | High when the device drives the data bus |
| busy | output | 1 | High during the programming period |
| err_flag | output | 1 | Burst crossed a page boundary |

## Verification
The bench builds the block with STORE_BITS=7, LOAD_TIMEOUT=40 and PROG_CYCLES=100. With these values the store holds two full pages, so every location can be written and read back in a few thousand cycles. A reference array in the bench checks every location after full and partial bursts, a cross-page burst, and writes issued while busy. Because the load and programming windows are short, the bench can sample `busy` a few cycles before and after each computed transition. It can also poll during programming and check that a gap just under the timeout keeps the load phase open.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    localparam int ADDR_W = 15;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } pg_state_e;

    typedef struct packed {
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_smp_t;

    localparam bus_smp_t BUS_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
                                      addr: '0, data: '0};

    function automatic logic is_write(input bus_smp_t s);
        return !s.ce_n && !s.we_n && s.oe_n;
    endfunction

    function automatic logic is_read(input bus_smp_t s);
        return !s.ce_n && !s.oe_n && s.we_n;
    endfunction

    function automatic logic [DATA_W-1:0] poll_byte(input logic [DATA_W-1:0] b);
        return {~b[DATA_W-1], b[DATA_W-2:0]};
    endfunction

endpackage

// File: rtl/ee_bus_sync.sv
module ee_bus_sync
    import eeprom_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_smp_t          raw,
    output bus_smp_t          cur,
    output logic              wr_end,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_req
);
    localparam int DEPTH = SYNC_STAGES + 1;

    bus_smp_t pipe [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) pipe[k] <= BUS_IDLE;
        end else begin
            pipe[0] <= raw;
            for (int k = 1; k < DEPTH; k++) pipe[k] <= pipe[k-1];
        end
    end

    bus_smp_t prev;
    assign cur     = pipe[SYNC_STAGES-1];
    assign prev    = pipe[SYNC_STAGES];
    assign wr_end  = is_write(prev) && !is_write(cur);
    assign wr_addr = prev.addr;
    assign wr_data = prev.data;
    assign rd_req  = is_read(cur);
endmodule

// File: rtl/ee_page_ctrl.sv
module ee_page_ctrl
    import eeprom_pkg::*;
#(
    parameter int PAGE_BITS    = 6,
    parameter int LOAD_TIMEOUT = 3750,
    parameter int PROG_CYCLES  = 1000
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  wr_end,
    input  logic [ADDR_W-1:0]                     wr_addr,
    input  logic [DATA_W-1:0]                     wr_data,
    output logic                                  busy,
    output logic                                  in_load,
    output logic                                  err_flag,
    output logic [DATA_W-1:0]                     last_byte,
    output logic                                  commit,
    output logic [ADDR_W-PAGE_BITS-1:0]           commit_tag,
    output logic [(1<<PAGE_BITS)-1:0]             commit_valid,
    output logic [(1<<PAGE_BITS)-1:0][DATA_W-1:0] commit_data
);
    localparam int PAGE_SZ = 1 << PAGE_BITS;
    localparam int TAG_W   = ADDR_W - PAGE_BITS;
    localparam int MAXCNT  = (LOAD_TIMEOUT > PROG_CYCLES) ? LOAD_TIMEOUT : PROG_CYCLES;
    localparam int CNT_W   = $clog2(MAXCNT + 1);
    localparam logic [CNT_W-1:0] LOAD_LAST = CNT_W'(LOAD_TIMEOUT - 1);
    localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_CYCLES - 1);

    pg_state_e          state;
    logic [CNT_W-1:0]   cnt;
    logic [TAG_W-1:0]   tag;
    logic [PAGE_SZ-1:0] valid;
    logic [PAGE_SZ-1:0][DATA_W-1:0] latch;

    logic [TAG_W-1:0]     in_tag;
    logic [PAGE_BITS-1:0] in_slot;
    assign in_tag  = wr_addr[ADDR_W-1:PAGE_BITS];
    assign in_slot = wr_addr[PAGE_BITS-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            tag       <= '0;
            valid     <= '0;
            latch     <= '0;
            err_flag  <= 1'b0;
            last_byte <= '0;
            commit    <= 1'b0;
        end else begin
            commit <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (wr_end) begin
                        state          <= ST_LOAD;
                        cnt            <= '0;
                        tag            <= in_tag;
                        valid          <= PAGE_SZ'(1) << in_slot;
                        latch[in_slot] <= wr_data;
                        last_byte      <= wr_data;
                        err_flag       <= 1'b0;
                    end
                end
                ST_LOAD: begin
                    if (wr_end) begin
                        cnt            <= '0;
                        valid[in_slot] <= 1'b1;
                        latch[in_slot] <= wr_data;
                        last_byte      <= wr_data;
                        if (in_tag != tag) err_flag <= 1'b1;
                    end else if (cnt == LOAD_LAST) begin
                        state  <= ST_PROG;
                        cnt    <= '0;
                        commit <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PROG: begin
                    if (cnt == PROG_LAST) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy         = (state == ST_PROG);
    assign in_load      = (state == ST_LOAD);
    assign commit_tag   = tag;
    assign commit_valid = valid;
    assign commit_data  = latch;
endmodule

// File: rtl/ee_array.sv
module ee_array
    import eeprom_pkg::*;
#(
    parameter int STORE_BITS = 9,
    parameter int PAGE_BITS  = 6
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  commit,
    input  logic [STORE_BITS-PAGE_BITS-1:0]       commit_pg,
    input  logic [(1<<PAGE_BITS)-1:0]             commit_valid,
    input  logic [(1<<PAGE_BITS)-1:0][DATA_W-1:0] commit_data,
    input  logic [STORE_BITS-1:0]                 rd_addr,
    output logic [DATA_W-1:0]                     rd_data
);
    localparam int DEPTH   = 1 << STORE_BITS;
    localparam int PAGE_SZ = 1 << PAGE_BITS;
    localparam logic [DATA_W-1:0] ERASED = '1;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
        end else if (commit) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (commit_valid[i % PAGE_SZ] && ((i / PAGE_SZ) == int'(commit_pg)))
                    mem[i] <= commit_data[i % PAGE_SZ];
            end
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eeprom_emul.sv
module eeprom_emul
    import eeprom_pkg::*;
#(
    parameter int STORE_BITS   = 9,
    parameter int PAGE_BITS    = 6,
    parameter int LOAD_TIMEOUT = 3750,
    parameter int PROG_CYCLES  = 1000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              busy,
    output logic              err_flag
);
    localparam int PAGE_SZ  = 1 << PAGE_BITS;
    localparam int PG_SEL_W = STORE_BITS - PAGE_BITS;

    bus_smp_t          raw, cur;
    logic              wr_end, rd_req, in_load, commit;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data, last_byte, rd_data;
    logic [ADDR_W-PAGE_BITS-1:0]       commit_tag;
    logic [PAGE_SZ-1:0]                commit_valid;
    logic [PAGE_SZ-1:0][DATA_W-1:0]    commit_data;

    assign raw = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n, addr: addr, data: data_in};

    ee_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .raw(raw), .cur(cur), .wr_end(wr_end),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_req(rd_req)
    );

    ee_page_ctrl #(
        .PAGE_BITS(PAGE_BITS), .LOAD_TIMEOUT(LOAD_TIMEOUT), .PROG_CYCLES(PROG_CYCLES)
    ) u_ctrl (
        .clk(clk), .rst(rst), .wr_end(wr_end), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .in_load(in_load), .err_flag(err_flag), .last_byte(last_byte),
        .commit(commit), .commit_tag(commit_tag), .commit_valid(commit_valid),
        .commit_data(commit_data)
    );

    ee_array #(.STORE_BITS(STORE_BITS), .PAGE_BITS(PAGE_BITS)) u_array (
        .clk(clk), .rst(rst), .commit(commit),
        .commit_pg(commit_tag[PG_SEL_W-1:0]), .commit_valid(commit_valid),
        .commit_data(commit_data), .rd_addr(cur.addr[STORE_BITS-1:0]),
        .rd_data(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            data_oe  <= 1'b0;
            data_out <= '0;
        end else begin
            data_oe  <= rd_req;
            data_out <= !rd_req ? '0 : (busy ? poll_byte(last_byte) : rd_data);
        end
    end
endmodule

// File: rtl/ee_checker.sv
module ee_checker
    import eeprom_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic [DATA_W-1:0] data_out,
    input logic              data_oe,
    input logic              busy,
    input logic              err_flag,
    input logic              wr_end,
    input logic              in_load,
    input logic [DATA_W-1:0] last_byte
);
    a_r10_drive_needs_read: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> ($past(!ce_n, 3) && $past(!oe_n, 3) && $past(we_n, 3)));

    a_r4_prog_after_load: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(in_load));

    a_r8_busy_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_end) |=> $stable(last_byte));

    a_r9_err_on_burst_byte: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flag) |-> ($past(wr_end) && $past(in_load)));

    a_r6_poll_value: assert property (@(posedge clk) disable iff (rst)
        (data_oe && $past(busy)) |->
            (data_out == {~$past(last_byte[DATA_W-1]), $past(last_byte[DATA_W-2:0])}));
endmodule

bind eeprom_emul ee_checker u_chk (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .data_out(data_out), .data_oe(data_oe), .busy(busy), .err_flag(err_flag),
    .wr_end(wr_end), .in_load(in_load), .last_byte(last_byte)
);

// File: tb/sim_eeprom_emul.sv
module sim_eeprom_emul;
    localparam int SB = 7;
    localparam int LT = 40;
    localparam int PC = 100;
    localparam int DEPTH = 1 << SB;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [14:0] addr = '0;
    logic [7:0]  data_in = '0;
    logic [7:0]  data_out;
    logic data_oe, busy, err_flag;

    int checks = 0;
    int fails = 0;
    logic [7:0] model [DEPTH];

    always #4 clk = ~clk;

    eeprom_emul #(.STORE_BITS(SB), .LOAD_TIMEOUT(LT), .PROG_CYCLES(PC)) u0 (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
        .data_in(data_in), .data_out(data_out), .data_oe(data_oe), .busy(busy),
        .err_flag(err_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        addr = 15'(a); data_in = 8'(d); ce_n = 0; oe_n = 1; we_n = 0;
        cyc(3);
        we_n = 1;
        cyc(1);
        ce_n = 1;
    endtask

    task automatic rd(input int a, output int d, output int o);
        @(negedge clk);
        addr = 15'(a); ce_n = 0; oe_n = 0; we_n = 1;
        cyc(5);
        d = int'(data_out); o = int'(data_oe);
        ce_n = 1; oe_n = 1;
        cyc(4);
    endtask

    // R4/R5/R6 around the end of a burst whose last strobe was released one cycle ago
    task automatic close_burst(input int last_d, input int probe_a);
        int d, o;
        cyc(LT - 4);
        chk("R4 busy still low before timeout", int'(busy), 0);
        cyc(8);
        chk("R4 busy high after timeout", int'(busy), 1);
        rd(probe_a, d, o);
        chk("R6 poll byte", d, int'({~last_d[7], last_d[6:0]}));
        chk("R10 poll drives bus", o, 1);
        cyc(PC);
        chk("R5 busy low after program time", int'(busy), 0);
    endtask

    task automatic sweep(input string req);
        int d, o;
        for (int a = 0; a < DEPTH; a++) begin
            rd(a, d, o);
            chk(req, d, int'(model[a]));
        end
    endtask

    function automatic int pat(input int i, input int k);
        return (i * 37 + k * 11 + 5) & 255;
    endfunction

    initial begin
        #(8 * 190000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int d, o;
        for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
        cyc(4);
        rst = 0;
        cyc(2);

        // R11 reset state
        chk("R11 busy after reset", int'(busy), 0);
        chk("R11 err after reset", int'(err_flag), 0);
        chk("R11 data_oe after reset", int'(data_oe), 0);
        sweep("R11 erased store");

        // R1 R3 full page 0 burst
        for (int i = 0; i < 64; i++) begin
            wr(i, pat(i, 1));
            model[i] = 8'(pat(i, 1));
        end
        close_burst(pat(63, 1), 3);
        chk("R9 clean burst no error", int'(err_flag), 0);

        // R7 partial page 1 burst: untouched slots keep 8'hFF
        wr(64, 8'h12); model[64] = 8'h12;
        wr(69, 8'hA5); model[69] = 8'hA5;
        wr(127, 8'h3C); model[127] = 8'h3C;
        close_burst(8'h3C, 70);
        sweep("R7 R3 store after bursts");

        // R2 write strobe with output enable low is not a write
        @(negedge clk);
        addr = 15'd5; data_in = 8'h00; ce_n = 0; oe_n = 0; we_n = 0;
        cyc(3);
        ce_n = 1;
        cyc(1);
        we_n = 1; oe_n = 1;
        cyc(LT + 10);
        chk("R2 no programming", int'(busy), 0);
        rd(5, d, o);
        chk("R2 byte unchanged", d, int'(model[5]));

        // R8 writes during busy ignored
        wr(10, 8'h77); model[10] = 8'h77;
        cyc(LT + 6);
        chk("R8 busy for ignore test", int'(busy), 1);
        wr(11, 8'h99);
        wr(10, 8'h01);
        cyc(PC + 10);
        chk("R8 busy done", int'(busy), 0);
        rd(10, d, o);
        chk("R8 committed byte kept", d, 8'h77);
        rd(11, d, o);
        chk("R8 ignored write", d, int'(model[11]));

        // R9 cross-page burst
        wr(66, 8'hC1); model[66] = 8'hC1;
        cyc(3);
        chk("R9 no error on first byte", int'(err_flag), 0);
        wr(9, 8'h5A); model[73] = 8'h5A;
        cyc(3);
        chk("R9 error set", int'(err_flag), 1);
        close_burst(8'h5A, 20);
        chk("R9 error sticky after program", int'(err_flag), 1);
        rd(9, d, o);
        chk("R9 other page untouched", d, int'(model[9]));
        rd(73, d, o);
        chk("R9 byte placed in first page", d, 8'h5A);
        wr(100, 8'h44); model[100] = 8'h44;
        cyc(3);
        chk("R9 error cleared by new burst", int'(err_flag), 0);
        close_burst(8'h44, 1);

        // R4 timer restarts with each byte
        wr(30, 8'hE0); model[30] = 8'hE0;
        cyc(LT - 8);
        chk("R4 before second byte", int'(busy), 0);
        wr(31, 8'hE1); model[31] = 8'hE1;
        cyc(LT - 8);
        chk("R4 restarted timer", int'(busy), 0);
        cyc(12);
        chk("R4 programming after restart", int'(busy), 1);
        cyc(PC + 5);
        chk("R5 done after restart", int'(busy), 0);

        // R10 bus drive conditions
        @(negedge clk);
        addr = 15'd30; ce_n = 1; oe_n = 0; we_n = 1;
        cyc(5);
        chk("R10 no drive with chip disabled", int'(data_oe), 0);
        chk("R10 zero when not driving", int'(data_out), 0);
        ce_n = 0; oe_n = 1;
        cyc(5);
        chk("R10 no drive with output disabled", int'(data_oe), 0);
        ce_n = 1;
        cyc(4);

        sweep("R7 final store");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule